// File: doc/BRIEF.md
# Programmable GPIO Port Register Bank

This block owns one general-purpose I/O port of `PIN_W` pins (eight by default) and the small register file that controls it. A host reaches the registers through a plain parallel access port: a command-byte address, a one-cycle write strobe with write data, and a one-cycle read strobe whose data is registered and appears on `rd_data` one cycle later. Each pin can be an input or an output. An output pin uses either a push-pull or an open-drain driver, and the pad is modelled by a separate output-enable and drive value for each pin.

Input levels pass through a two-flop synchronizer. A change on a synchronized input pin sets a sticky status flag. The flags feed an active-low interrupt through a per-pin mask and a global enable. A small two-state machine owns the interrupt line. Its states are `IRQ_QUIET` and `IRQ_ASSERTED`. The RAISE transition (quiet to asserted) fires when an enabled, masked-in flag is pending on an input pin. The DROP transition (asserted to quiet) fires when no such flag remains.

Setting the fan-mode bit hands the upper `FAN_PINS` pins to an external fan controller. That controller supplies active-low drive levels on `fan_ctl_n`, and the block presents the stored fan-speed code to it on `fan_speed`.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every register reads 0x00 except the data register, whose stored value is 0xFF; `pin_oe` is 0x00 and `irq_n` is 1.
- R2: The address map is 0x00 config, 0x01 direction, 0x02 driver type, 0x03 status, 0x04 mask, 0x05 data and 0x06 fan speed. Config bit 7 is the global interrupt enable and config bit 6 is fan mode; the other config bits read 0. Fan speed keeps bits 2:0 only. Writes to 0x03 or to any address of 0x07 and above change nothing, and reads of unmapped addresses return 0x00.
- R3: A direction bit of 1 makes its pin an output. A push-pull output (driver bit 1) drives `pin_oe`=1 and `pin_out`=data. An open-drain output (driver bit 0) drives `pin_out`=0 and sets `pin_oe` only while its data bit is 0. An input pin has `pin_oe`=0.
- R4: A read of the data register returns the stored data bit for output pins and the synchronized pin level for input pins. A pin change becomes visible to a read after two clock edges.
- R5: A data write updates only the bits of pins that are outputs at that time; the other stored bits keep their value.
- R6: A status bit sets on the third clock edge after its input pin changes. A pin that is an output does not set its status bit.
- R7: A read of the status register returns the flags and clears all of them at that same edge. A change flagged at the edge of the read stays set.
- R8: `irq_n` goes low one edge after the global enable is 1 and some status bit of an input pin is set with its mask bit at 1. It returns high one edge after that condition ends.
- R9: In fan mode the upper `FAN_PINS` pins ignore the direction, driver and data settings. Each one is open-drain, with `pin_out`=0 and `pin_oe` equal to the inverse of its `fan_ctl_n` bit. A data read returns their pin levels. `fan_mode` and `fan_speed` mirror the stored settings.
- R10: In fan mode the upper pins set no status bit and raise no interrupt, while the lower pins keep their normal behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_addr | input | 8 | Command-byte register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | PIN_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | PIN_W | Registered read data, valid the cycle after `rd_en` |
| pin_in | input | PIN_W | Pad input levels (asynchronous) |
| pin_oe | output | PIN_W | Pad output enable per pin |
| pin_out | output | PIN_W | Pad drive value per pin |
| fan_ctl_n | input | FAN_PINS | Active-low drive levels from the fan controller |
| fan_mode | output | 1 | Fan mode is selected |
| fan_speed | output | FAN_SPD_W | Stored fan-speed code |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Some properties are checked by the assertions on every cycle:
- Input pins never have an output enable.
- Open-drain pins never drive high.
- Fan pins never drive high and never flag a change.
- The interrupt is low only if the enable was set on the cycle before.
- A status read leaves only the flags that arrived at the same edge.
- Reserved config bits read back as zero.

Other behaviours need the bench's scenarios:
- The synchronizer and status latencies.
- The effect of data writes on input bits.
- Ignored and unmapped addresses.
- The same-edge race between a change and a status read.
- Mask and enable ordering.
- Handing the upper pins to the fan controller.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam logic [7:0] ADDR_CFG  = 8'h00;
    localparam logic [7:0] ADDR_DIR  = 8'h01;
    localparam logic [7:0] ADDR_DRV  = 8'h02;
    localparam logic [7:0] ADDR_STAT = 8'h03;
    localparam logic [7:0] ADDR_MASK = 8'h04;
    localparam logic [7:0] ADDR_DATA = 8'h05;
    localparam logic [7:0] ADDR_FAN  = 8'h06;

    localparam int CFG_IE_BIT  = 7;
    localparam int CFG_FAN_BIT = 6;

    typedef enum logic {
        IRQ_QUIET    = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int         W       = 8,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain[s] <= d_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_change_det.sv
module gpio_change_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] eligible,
    output logic [W-1:0] chg
);
    logic [W-1:0] prev_q;

    // prev tracks every pin so that a direction change never looks like an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    assign chg = (lvl ^ prev_q) & eligible;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int PIN_W     = 8,
    parameter int FAN_SPD_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           cmd_addr,
    input  logic                 wr_en,
    input  logic [PIN_W-1:0]     wr_data,
    input  logic                 rd_en,
    input  logic [PIN_W-1:0]     pin_lvl,
    input  logic [PIN_W-1:0]     drive_sel,
    input  logic [PIN_W-1:0]     chg_set,
    output logic [PIN_W-1:0]     rd_data,
    output logic                 ie_q,
    output logic                 fan_q,
    output logic [PIN_W-1:0]     dir_q,
    output logic [PIN_W-1:0]     drv_q,
    output logic [PIN_W-1:0]     mask_q,
    output logic [PIN_W-1:0]     data_q,
    output logic [PIN_W-1:0]     status_q,
    output logic [FAN_SPD_W-1:0] fan_speed_q
);
    logic             rd_stat;
    logic [PIN_W-1:0] cfg_view;
    logic [PIN_W-1:0] data_view;
    logic [PIN_W-1:0] rd_mux;

    assign rd_stat = rd_en && (cmd_addr == ADDR_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q        <= 1'b0;
            fan_q       <= 1'b0;
            dir_q       <= '0;
            drv_q       <= '0;
            mask_q      <= '0;
            data_q      <= '1;
            fan_speed_q <= '0;
        end else if (wr_en) begin
            case (cmd_addr)
                ADDR_CFG: begin
                    ie_q  <= wr_data[CFG_IE_BIT];
                    fan_q <= wr_data[CFG_FAN_BIT];
                end
                ADDR_DIR:  dir_q       <= wr_data;
                ADDR_DRV:  drv_q       <= wr_data;
                ADDR_MASK: mask_q      <= wr_data;
                ADDR_DATA: data_q      <= (wr_data & dir_q) | (data_q & ~dir_q);
                ADDR_FAN:  fan_speed_q <= wr_data[FAN_SPD_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= chg_set | (rd_stat ? '0 : status_q);
    end

    always_comb begin
        cfg_view              = '0;
        cfg_view[CFG_IE_BIT]  = ie_q;
        cfg_view[CFG_FAN_BIT] = fan_q;
        data_view = (data_q & drive_sel) | (pin_lvl & ~drive_sel);
        case (cmd_addr)
            ADDR_CFG:  rd_mux = cfg_view;
            ADDR_DIR:  rd_mux = dir_q;
            ADDR_DRV:  rd_mux = drv_q;
            ADDR_STAT: rd_mux = status_q;
            ADDR_MASK: rd_mux = mask_q;
            ADDR_DATA: rd_mux = data_view;
            ADDR_FAN:  rd_mux = PIN_W'(fan_speed_q);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int PIN_W    = 8,
    parameter int FAN_PINS = 4
) (
    input  logic [PIN_W-1:0]    dir_q,
    input  logic [PIN_W-1:0]    drv_q,
    input  logic [PIN_W-1:0]    data_q,
    input  logic                fan_q,
    input  logic [FAN_PINS-1:0] fan_ctl_n,
    output logic [PIN_W-1:0]    pin_oe,
    output logic [PIN_W-1:0]    pin_out
);
    localparam int FAN_LO = PIN_W - FAN_PINS;

    generate
        for (genvar i = 0; i < PIN_W; i++) begin : g_pin
            logic norm_oe;
            logic norm_out;

            always_comb begin
                if (!dir_q[i]) begin
                    norm_oe  = 1'b0;
                    norm_out = 1'b0;
                end else if (drv_q[i]) begin
                    norm_oe  = 1'b1;
                    norm_out = data_q[i];
                end else begin
                    norm_oe  = ~data_q[i];
                    norm_out = 1'b0;
                end
            end

            if (i >= FAN_LO) begin : g_fan
                assign pin_oe[i]  = fan_q ? ~fan_ctl_n[i-FAN_LO] : norm_oe;
                assign pin_out[i] = fan_q ? 1'b0 : norm_out;
            end else begin : g_plain
                assign pin_oe[i]  = norm_oe;
                assign pin_out[i] = norm_out;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_fsm.sv
module gpio_irq_fsm
    import gpio_bank_pkg::*;
#(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ie_q,
    input  logic [PIN_W-1:0] status_q,
    input  logic [PIN_W-1:0] mask_q,
    input  logic [PIN_W-1:0] in_sel,
    output logic             irq_n
);
    irq_state_e state_q, state_d;
    logic       pending;

    assign pending = ie_q && |(status_q & mask_q & in_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:    if (pending)  state_d = IRQ_ASSERTED; // RAISE
            IRQ_ASSERTED: if (!pending) state_d = IRQ_QUIET;    // DROP
            default:                    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_ASSERTED: irq_n = 1'b0;
            default:      irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int PIN_W       = 8,
    parameter int FAN_PINS    = 4,
    parameter int FAN_SPD_W   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           cmd_addr,
    input  logic                 wr_en,
    input  logic [PIN_W-1:0]     wr_data,
    input  logic                 rd_en,
    output logic [PIN_W-1:0]     rd_data,
    input  logic [PIN_W-1:0]     pin_in,
    output logic [PIN_W-1:0]     pin_oe,
    output logic [PIN_W-1:0]     pin_out,
    input  logic [FAN_PINS-1:0]  fan_ctl_n,
    output logic                 fan_mode,
    output logic [FAN_SPD_W-1:0] fan_speed,
    output logic                 irq_n
);
    localparam int             FAN_LO   = PIN_W - FAN_PINS;
    localparam logic [PIN_W-1:0] FAN_ZONE = {{FAN_PINS{1'b1}}, {FAN_LO{1'b0}}};

    logic [PIN_W-1:0] pin_lvl;
    logic [PIN_W-1:0] chg_q;
    logic [PIN_W-1:0] dir_q, drv_q, mask_q, data_q, status_q;
    logic [PIN_W-1:0] fan_claim;
    logic [PIN_W-1:0] drive_sel;
    logic [PIN_W-1:0] in_sel;
    logic             ie_q, fan_q;

    assign fan_claim = fan_q ? FAN_ZONE : '0;
    assign drive_sel = dir_q & ~fan_claim;
    assign in_sel    = ~dir_q & ~fan_claim;
    assign fan_mode  = fan_q;

    gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_lvl)
    );

    gpio_change_det #(.W(PIN_W)) u_chg (
        .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .eligible(in_sel), .chg(chg_q)
    );

    gpio_regfile #(.PIN_W(PIN_W), .FAN_SPD_W(FAN_SPD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .pin_lvl(pin_lvl),
        .drive_sel(drive_sel), .chg_set(chg_q), .rd_data(rd_data),
        .ie_q(ie_q), .fan_q(fan_q), .dir_q(dir_q), .drv_q(drv_q),
        .mask_q(mask_q), .data_q(data_q), .status_q(status_q),
        .fan_speed_q(fan_speed)
    );

    gpio_pad_ctrl #(.PIN_W(PIN_W), .FAN_PINS(FAN_PINS)) u_pad (
        .dir_q(dir_q), .drv_q(drv_q), .data_q(data_q), .fan_q(fan_q),
        .fan_ctl_n(fan_ctl_n), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    gpio_irq_fsm #(.PIN_W(PIN_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .ie_q(ie_q), .status_q(status_q),
        .mask_q(mask_q), .in_sel(in_sel), .irq_n(irq_n)
    );
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int PIN_W    = 8,
    parameter int FAN_PINS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [7:0]       cmd_addr,
    input logic [PIN_W-1:0] rd_data,
    input logic             irq_n,
    input logic [PIN_W-1:0] pin_oe,
    input logic [PIN_W-1:0] pin_out,
    input logic             fan_mode,
    input logic [PIN_W-1:0] dir_q,
    input logic [PIN_W-1:0] drv_q,
    input logic             ie_q,
    input logic [PIN_W-1:0] status_q,
    input logic [PIN_W-1:0] chg_q
);
    localparam int             FAN_LO   = PIN_W - FAN_PINS;
    localparam logic [PIN_W-1:0] CFG_RSV =
        ~((PIN_W'(1) << CFG_IE_BIT) | (PIN_W'(1) << CFG_FAN_BIT));

    assert_cfg_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cmd_addr == ADDR_CFG) |=> ((rd_data & CFG_RSV) == '0));

    assert_input_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fan_mode |-> ((pin_oe & ~dir_q) == '0));

    assert_od_never_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~drv_q) == '0));

    assert_status_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cmd_addr == ADDR_STAT) |=> ((status_q & ~$past(chg_q)) == '0));

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(ie_q));

    assert_fan_pins_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fan_mode |-> (pin_out[PIN_W-1:FAN_LO] == '0));

    assert_fan_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fan_mode |-> (chg_q[PIN_W-1:FAN_LO] == '0));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.PIN_W(PIN_W), .FAN_PINS(FAN_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .cmd_addr(cmd_addr),
    .rd_data(rd_data), .irq_n(irq_n), .pin_oe(pin_oe), .pin_out(pin_out),
    .fan_mode(fan_mode), .dir_q(dir_q), .drv_q(drv_q), .ie_q(ie_q),
    .status_q(status_q), .chg_q(chg_q)
);

// File: tb/gpio_port_bank_tb.sv
`timescale 1ns/1ps
module gpio_port_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] pin_oe, pin_out;
    logic [3:0] fan_ctl_n = 4'hF;
    logic       fan_mode;
    logic [2:0] fan_speed;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct { logic [7:0] exp; string req; } sb_item_t;
    sb_item_t sb_q[$];
    logic     rd_pend = 1'b0;

    always #10 clk = ~clk;

    gpio_port_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .fan_ctl_n(fan_ctl_n),
        .fan_mode(fan_mode), .fan_speed(fan_speed), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        cmd_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        sb_item_t it;
        it.exp = exp; it.req = req;
        sb_q.push_back(it);
        cmd_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: the read captured at a rising edge is compared at the next falling edge
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", 8'h00, 8'h01);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.req, rd_data, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 pin_oe", pin_oe, 8'h00);
        do_read(8'h00, 8'h00, "R1 cfg");
        do_read(8'h01, 8'h00, "R1 dir");
        do_read(8'h02, 8'h00, "R1 drv");
        do_read(8'h03, 8'h00, "R1 status");
        do_read(8'h04, 8'h00, "R1 mask");
        do_read(8'h06, 8'h00, "R1 fan");
        do_read(8'h05, 8'hFF, "R1 data");

        // R2: reserved bits, ignored writes, unmapped addresses
        do_write(8'h00, 8'hFF);
        do_read(8'h00, 8'hC0, "R2 cfg reserved");
        do_write(8'h00, 8'h00);
        do_write(8'h06, 8'hFF);
        do_read(8'h06, 8'h07, "R2 fan width");
        check("R2 fan_speed port", {5'd0, fan_speed}, 8'h07);
        do_write(8'h03, 8'hAA);
        do_read(8'h03, 8'h00, "R2 status write ignored");
        do_write(8'h09, 8'h55);
        do_read(8'h01, 8'h00, "R2 unmapped write ignored");
        do_read(8'h09, 8'h00, "R2 unmapped read");
        do_write(8'h06, 8'h00);

        // R3 / R1: open-drain then push-pull on pin 0, data reset 0xFF
        do_write(8'h01, 8'h01);
        do_read(8'h05, 8'hFF, "R1 data reset value");
        check("R3 od high released", pin_oe, 8'h00);
        do_write(8'h05, 8'h00);
        check("R3 od low oe", pin_oe, 8'h01);
        check("R3 od low out", pin_out, 8'h00);
        do_write(8'h02, 8'h01);
        check("R3 pp low oe", pin_oe, 8'h01);
        check("R3 pp low out", pin_out, 8'h00);
        do_write(8'h05, 8'h01);
        check("R3 pp high out", pin_out, 8'h01);
        // R5: write with only pin 0 as output
        do_write(8'h05, 8'h00);
        do_write(8'h01, 8'hFF);
        do_write(8'h02, 8'h00);
        do_read(8'h05, 8'hFE, "R5 input bits kept");
        check("R5 od oe", pin_oe, 8'h01);
        do_write(8'h01, 8'h00);

        // R4 / R6 / R7: input change, sync latency, status set and clear
        pin_in = 8'h5A;
        do_read(8'h05, 8'hFF, "R4 before sync");
        tick(2);
        do_read(8'h05, 8'h5A, "R4 synced level");
        do_read(8'h03, 8'hA5, "R6 status set");
        do_read(8'h03, 8'h00, "R7 status cleared");
        check("R8 no irq without enable", {7'd0, irq_n}, 8'h01);

        // R6: output pins do not flag
        do_write(8'h01, 8'h0F);
        pin_in = 8'h55;
        tick(4);
        do_read(8'h03, 8'h00, "R6 outputs no flag");
        do_write(8'h01, 8'h00);

        // R8: enabled and masked interrupt timing
        do_write(8'h00, 8'h80);
        do_write(8'h04, 8'h01);
        pin_in = 8'h54;
        tick(3);
        check("R8 irq not yet", {7'd0, irq_n}, 8'h01);
        tick(1);
        check("R8 irq raised", {7'd0, irq_n}, 8'h00);
        do_read(8'h03, 8'h01, "R8 status bit0");
        check("R8 irq held at read", {7'd0, irq_n}, 8'h00);
        tick(1);
        check("R8 irq dropped", {7'd0, irq_n}, 8'h01);
        pin_in = 8'h56;
        tick(5);
        check("R8 masked bit no irq", {7'd0, irq_n}, 8'h01);
        do_read(8'h03, 8'h02, "R8 masked flag");
        do_write(8'h00, 8'h00);
        do_write(8'h04, 8'h02);
        pin_in = 8'h54;
        tick(5);
        check("R8 enable off", {7'd0, irq_n}, 8'h01);
        do_write(8'h00, 8'h80);
        check("R8 enable edge", {7'd0, irq_n}, 8'h01);
        tick(1);
        check("R8 late enable", {7'd0, irq_n}, 8'h00);
        do_read(8'h03, 8'h02, "R8 flag kept");
        do_write(8'h00, 8'h00);
        do_write(8'h04, 8'h00);

        // R7: change flagged on the same edge as a status read
        pin_in = 8'h5C;
        tick(2);
        do_read(8'h03, 8'h00, "R7 race read");
        do_read(8'h03, 8'h08, "R7 race kept");

        // R9: fan mode takes the upper pins
        do_write(8'h01, 8'hFF);
        do_write(8'h02, 8'hFF);
        do_write(8'h05, 8'hFF);
        check("R3 pp all high", pin_out, 8'hFF);
        fan_ctl_n = 4'b1010;
        do_write(8'h00, 8'h40);
        check("R9 fan oe", pin_oe, 8'h5F);
        check("R9 fan out", pin_out, 8'h0F);
        check("R9 fan_mode", {7'd0, fan_mode}, 8'h01);
        do_write(8'h06, 8'h05);
        check("R9 fan_speed", {5'd0, fan_speed}, 8'h05);
        fan_ctl_n = 4'b0011;
        tick(1);
        check("R9 fan follow", pin_oe, 8'hCF);
        do_read(8'h05, 8'h5F, "R9 data read");

        // R10: fan pins raise nothing, lower pins still do
        do_write(8'h01, 8'h00);
        do_write(8'h00, 8'hC0);
        do_write(8'h04, 8'hFF);
        pin_in = 8'hAC;
        tick(5);
        check("R10 fan pin no irq", {7'd0, irq_n}, 8'h01);
        do_read(8'h03, 8'h00, "R10 fan pin no flag");
        pin_in = 8'hAD;
        tick(4);
        check("R10 lower irq", {7'd0, irq_n}, 8'h00);
        do_read(8'h03, 8'h01, "R10 lower flag");

        tick(2);
        if (sb_q.size() != 0) check("scoreboard leftover", 8'(sb_q.size()), 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule